// File: doc/BRIEF.md
# Gated Binary Clock Divider

This block takes a single input clock and derives a set of slower clocks from it. With the default of three stages, it produces one half, one quarter and one eighth of the input rate. All outputs are bits of one synchronous binary counter, and that counter runs on a single internal clock. When two or more outputs switch on the same input edge, they switch together, with no offset between stages.

An active-low run control starts and stops the counter. The control is captured on the falling edge of the input clock. The internal gated clock is therefore opened or closed only while the input clock is low, so a partial clock pulse can never reach the counter.

An asynchronous master reset clears every output. It also forces the internal run state to "running". When reset is released, the counter advances on the very next rising edge. This lets several copies of the block be brought into step by sharing one reset.

Top module: `gated_clk_divider`

## Requirements
- R1: Output bit k toggles at 1/2^(k+1) of the rate of counted input rising edges. The output vector, read as an unsigned number, increments by one on each counted edge and wraps from all ones to zero.
- R2: Outside reset, the outputs change only at rising edges of `clk_in`, and all bits that change do so at the same edge.
- R3: With `en_n` sampled low and `mr` low, every rising edge of `clk_in` advances the count.
- R4: With `en_n` sampled high, rising edges of `clk_in` leave the outputs unchanged.
- R5: While `mr` is high, all outputs are 0. The clear takes effect at once, without waiting for a clock edge, and is independent of `en_n`.
- R6: `en_n` is sampled on the falling edge of `clk_in`. A change made after a falling edge does not affect the rising edge that immediately follows.
- R7: Reset leaves the run state enabled. The first rising edge after `mr` is released advances the count even if `en_n` went high after the last falling edge.
- R8: The internal gated clock produces exactly one rising edge per enabled input rising edge, and no extra or shortened pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| en_n | input | 1 | Active-low run control, sampled on the falling edge |
| mr | input | 1 | Asynchronous master reset, active high |
| div_q | output | STAGES | Divided clocks; bit k runs at the input rate over 2^(k+1) |

## Verification
The bench changes the run control on both sides of the falling edge. A design that sampled it on the rising edge, or sampled it combinationally, would count one edge too many or one too few around a stop or a start. It releases reset just before a rising edge while the run control is high. A design that did not reset the run state to enabled would miss that first count. It also counts output transitions against the edges the model says were enabled. An extra gated pulse or an output change on a falling edge shows up as a count mismatch or as a transition seen while the clock is low.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
   // Upper bound on divider depth accepted by the top module
   localparam int unsigned GCD_MAX_STAGES = 16;

   // Value the run state takes in reset: running
   localparam logic GCD_RUN_AFTER_RESET = 1'b1;

   // Rate divisor of stage k
   function automatic int unsigned gcd_divisor(input int unsigned k);
      return 32'd2 << k;
   endfunction
endpackage

// File: rtl/gcd_enable_sync.sv
module gcd_enable_sync
   import gcd_pkg::*;
(
   input  logic clk_in,
   input  logic mr,
   input  logic en_n,
   output logic run_q
);
   // Captured while the clock falls, so the gate only moves during the low phase
   always_ff @(negedge clk_in or posedge mr) begin
      if (mr) run_q <= GCD_RUN_AFTER_RESET;
      else    run_q <= ~en_n;
   end
endmodule

// File: rtl/gcd_clock_gate.sv
module gcd_clock_gate (
   input  logic clk_in,
   input  logic run_q,
   output logic clk_gate
);
   // run_q is stable whenever clk_in is high, so the AND cannot chop a pulse
   assign clk_gate = clk_in & run_q;
endmodule

// File: rtl/gcd_sync_counter.sv
module gcd_sync_counter #(
   parameter int unsigned STAGES = 3
) (
   input  logic              clk,
   input  logic              rst,
   output logic [STAGES-1:0] cnt_q
);
   localparam int unsigned LAST = STAGES - 1;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic stage_q;
      logic toggle;

      if (k == 0) begin : g_lsb
         assign toggle = 1'b1;
      end else begin : g_upper
         // Toggle when every lower stage is high: all stages share one clock
         assign toggle = &cnt_q[k-1:0];
      end

      always_ff @(posedge clk or posedge rst) begin
         if (rst)         stage_q <= 1'b0;
         else if (toggle) stage_q <= ~stage_q;
      end

      assign cnt_q[k] = stage_q;
   end

   if (LAST >= gcd_pkg::GCD_MAX_STAGES) begin : g_depth_err
      $error("gcd_sync_counter: STAGES out of range");
   end
endmodule

// File: rtl/gated_clk_divider.sv
module gated_clk_divider
   import gcd_pkg::*;
#(
   parameter int unsigned STAGES = 3
) (
   input  logic              clk_in,
   input  logic              en_n,
   input  logic              mr,
   output logic [STAGES-1:0] div_q
);
   localparam int unsigned SLOWEST_DIV = 2 << (STAGES - 1);

   if (STAGES < 1 || STAGES > GCD_MAX_STAGES) begin : g_param_err
      $error("gated_clk_divider: STAGES must be 1..%0d", GCD_MAX_STAGES);
   end
   if (SLOWEST_DIV != gcd_divisor(STAGES - 1)) begin : g_div_err
      $error("gated_clk_divider: divisor mismatch");
   end

   logic run_q;
   logic clk_gate;

   gcd_enable_sync u_en_sync (
      .clk_in (clk_in),
      .mr     (mr),
      .en_n   (en_n),
      .run_q  (run_q)
   );

   gcd_clock_gate u_gate (
      .clk_in   (clk_in),
      .run_q    (run_q),
      .clk_gate (clk_gate)
   );

   gcd_sync_counter #(.STAGES(STAGES)) u_cnt (
      .clk   (clk_gate),
      .rst   (mr),
      .cnt_q (div_q)
   );
endmodule

// File: rtl/gated_clk_divider_chk.sv
module gated_clk_divider_chk #(
   parameter int unsigned STAGES = 3
) (
   input logic              clk_in,
   input logic              mr,
   input logic              run_q,
   input logic              clk_gate,
   input logic [STAGES-1:0] div_q
);
   logic [7:0] gate_edges;
   logic [7:0] run_edges;

   always_ff @(posedge clk_gate or posedge mr) begin
      if (mr) gate_edges <= '0;
      else    gate_edges <= gate_edges + 8'd1;
   end

   always_ff @(posedge clk_in or posedge mr) begin
      if (mr)         run_edges <= '0;
      else if (run_q) run_edges <= run_edges + 8'd1;
   end

   // R5
   reset_clears_chk: assert property (@(posedge clk_in) mr |-> div_q == '0);

   // R3
   advance_chk: assert property (@(posedge clk_in) disable iff (mr)
      run_q |=> div_q == $past(div_q) + 1'b1);

   // R4
   hold_chk: assert property (@(posedge clk_in) disable iff (mr)
      !run_q |=> $stable(div_q));

   // R8
   no_runt_chk: assert property (@(negedge clk_in) disable iff (mr)
      gate_edges == run_edges);
endmodule

bind gated_clk_divider gated_clk_divider_chk #(.STAGES(STAGES)) u_chk (
   .clk_in   (clk_in),
   .mr       (mr),
   .run_q    (run_q),
   .clk_gate (clk_gate),
   .div_q    (div_q)
);

// File: tb/gated_clk_divider_bench.sv
`timescale 1ns/1ps
module gated_clk_divider_bench;
   localparam int unsigned S = 3;

   logic         clk_in;
   logic         en_n;
   logic         mr;
   logic [S-1:0] div_q;

   int checks;
   int failures;
   int bad_edge;
   int q0_changes;
   int advances;

   gated_clk_divider #(.STAGES(S)) u_gated_clk_divider (
      .clk_in (clk_in),
      .en_n   (en_n),
      .mr     (mr),
      .div_q  (div_q)
   );

   initial clk_in = 1'b0;
   always #2.5 clk_in = ~clk_in;

   // Outputs must only move while the clock is high (at its rising edge)
   always @(div_q) if (mr === 1'b0 && clk_in !== 1'b1) bad_edge++;
   always @(div_q[0]) if (mr === 1'b0) q0_changes++;

   function automatic logic [S-1:0] next_count(input logic [S-1:0] v, input bit run);
      return run ? v + 1'b1 : v;
   endfunction

   task automatic check(input string tag, input logic [S-1:0] act, input logic [S-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: div_q=%0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk_in);
      #1;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #1000000;
      checks++;
      failures++;
      $display("FAIL watchdog: expired, expected completion");
      summary();
   end

   initial begin
      logic [S-1:0] exp;
      bit           prev_mr;
      bit           run;
      void'($urandom(32'h5eed_0042));
      checks = 0; failures = 0; bad_edge = 0;
      mr = 1'b1; en_n = 1'b0;
      tick(); tick();
      check("R5 reset state", div_q, '0);

      mr = 1'b0; exp = '0; prev_mr = 1'b0; run = 1'b1;
      q0_changes = 0; advances = 0;
      for (int i = 0; i < 400; i++) begin
         tick();
         if (!prev_mr) begin
            if (run) advances++;
            exp = next_count(exp, run);
         end
         check(run ? "R3 advance" : "R4 hold", div_q, exp);
         mr   = ($urandom_range(99) < 3);
         en_n = ($urandom_range(99) < 30);
         prev_mr = mr;
         run = mr ? 1'b1 : !en_n;
         if (mr) begin
            exp = '0;
            #0.2 check("R5 async clear", div_q, exp);
         end
      end
      tick();
      if (!prev_mr && run) advances++;
      mr = 1'b1;
      checks++;
      if (q0_changes != advances) begin
         failures++;
         $display("FAIL R8: lsb transitions=%0d expected %0d", q0_changes, advances);
      end

      // R6: late disable and late enable are seen one edge later
      tick();
      mr = 1'b0; en_n = 1'b0;
      tick(); check("R3 first count", div_q, 3'd1);
      @(negedge clk_in); #0.5 en_n = 1'b1;
      tick(); check("R6 late disable", div_q, 3'd2);
      tick(); check("R4 held", div_q, 3'd2);
      @(negedge clk_in); #0.5 en_n = 1'b0;
      tick(); check("R6 late enable", div_q, 3'd2);
      tick(); check("R6 resumed", div_q, 3'd3);

      // R1: full wrap and per-bit rates
      mr = 1'b1; #0.5 check("R5 mid clear", div_q, '0);
      tick(); mr = 1'b0;
      for (int n = 1; n <= 16; n++) begin
         tick();
         check("R1 count sequence", div_q, S'(n));
      end
      check("R1 wrap to zero", div_q, '0);

      // R7: release just before a rising edge with en_n high
      en_n = 1'b1; mr = 1'b1;
      tick();
      @(negedge clk_in); #0.5 mr = 1'b0;
      tick(); check("R7 first edge after release", div_q, 3'd1);
      tick(); check("R7 then holds", div_q, 3'd1);

      checks++;
      if (bad_edge != 0) begin
         failures++;
         $display("FAIL R2: off-edge transitions=%0d expected 0", bad_edge);
      end
      summary();
   end
endmodule